// File: doc/BRIEF.md
# Deadline-aware warning-zone bus arbiter

This block decides which of several masters owns a shared bus. Some masters carry real-time deadlines and the rest do not. When a real-time master raises its request, the arbiter samples the transfer length that master declares. From that length it works out a relative deadline and a warning-zone length. While the request waits, a per-master time-to-deadline counter runs down by one every cycle.

A waiting real-time request whose remaining time has dropped below its warning-zone length, or has reached zero, is promoted above every other requester. Among promoted requests, the one closest to its deadline wins. When nothing is promoted, a rotating pointer picks among all requesters. A grant is never taken away: the owner keeps the bus until it pulses `done`. With no requests, a fixed default master is granted and the bus is marked free.

Two further outputs support the rest of the system. A one-cycle miss pulse flags a deadline that expired before the grant, and the request stays pending at top priority. A clock-enable output tells an external gating cell when the deadline counters need their clock.

Top module: `dz_bus_arbiter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `held` is 0, `grant_id` equals the default master DFLT (3 by default), `miss` is all zeros and `cnt_clk_en` is 0.
- R2: In a cycle where `held` is 0 and `req` is all zeros, the next edge leaves `held` at 0 and `grant_id` at DFLT.
- R3: A real-time master (bit set in RT_MASK, default 4'b0011) whose request is seen while it is not pending and not the owner has its counter loaded at the next edge with D = E + floor(E/2) + floor(E/4). E is its `xfer_len` field, bits [i*LEN_W +: LEN_W]. While it waits, the counter decrements by 1 per cycle and stops at 0. `miss[i]` is high for exactly the first cycle in which the pending counter equals 0.
- R4: A pending real-time requester is in its zone when its remaining time is below W = floor((E + D)/2) or equals 0. Any in-zone requester wins arbitration over every requester that is not in its zone, including non-real-time ones.
- R5: Among several in-zone requesters, the one with the smallest remaining time wins, and equal times go to the lower index.
- R6: With no requester in its zone, the winner is the first requester at or after the rotating pointer in ascending index order, wrapping around. After every grant the pointer becomes (winner + 1) mod N, and it is 0 after reset.
- R7: While `held` is 1 and `done` is 0, `grant_id` does not change. When `held` and `done` are both 1, the next edge sets `held` to 0 and `grant_id` to DFLT. `done` has no effect while `held` is 0.
- R8: In a cycle where `held` is 0 and some `req` bit is 1, the winner is granted at the next edge with `held` 1. A master that is granted in the same edge its request is first seen gets no deadline load, and a request held high by the current owner starts none.
- R9: `cnt_clk_en` is 1 exactly when some real-time master has `req` high or has a pending request.
- R10: `grant` is one-hot with its set bit at position `grant_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N | Request per master, held until granted |
| xfer_len | input | N*LEN_W | Declared execution length per master, field i at [i*LEN_W +: LEN_W] |
| done | input | 1 | Owner's end-of-transfer pulse |
| grant | output | N | One-hot grant |
| grant_id | output | $clog2(N) | Index of the granted master |
| held | output | 1 | Bus owned by a requester (0 means default master idling) |
| miss | output | N | One-cycle deadline-miss pulse per master |
| cnt_clk_en | output | 1 | Enable for the deadline-counter clock gate |

## Verification
The bench aims at the moments where priority changes hands. One is an in-zone real-time master that the rotating pointer would have skipped: a design that ignored zone status would hand the bus to the non-real-time neighbour. Another is two in-zone requests with different and then equal remaining times: an off-by-one comparison or the wrong tie-break would grant the other master. The miss pulse is timed exactly from the request edge, which catches a wrong slack formula or a counter that wraps below zero. Further checks cover a `done` pulse while the bus is free, which must leave the state alone, and long random traffic. The random traffic catches pointer updates that skip or repeat a master and deadlines reloaded while the owner keeps its request high.

// File: rtl/dz_arb_pkg.sv
// Package: shared arithmetic for the deadline arbiter.
// Assumes execution lengths are unsigned and small enough for 32-bit math.
package dz_arb_pkg;

    // Relative deadline: execution time plus three quarters of it as slack.
    function automatic int unsigned dz_deadline(input int unsigned e);
        return e + (e >> 1) + (e >> 2);
    endfunction

    // Warning-zone length: mean of execution time and deadline.
    function automatic int unsigned dz_zone_len(input int unsigned e);
        return (e + dz_deadline(e)) >> 1;
    endfunction

endpackage

// File: rtl/dz_deadline_slot.sv
// Module: per-master deadline tracker for one real-time master.
// Loads deadline and zone length when a new request is seen, counts the
// remaining time down while waiting and flags zone entry and a first miss.
// Assumes the master keeps req high until it is granted.
module dz_deadline_slot
    import dz_arb_pkg::*;
#(
    parameter int LEN_W = 6,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             req,
    input  logic             take,
    input  logic             busy,
    input  logic [LEN_W-1:0] len,
    output logic             pend,
    output logic [CNT_W-1:0] ttd,
    output logic             in_zone,
    output logic             miss
);

    logic [CNT_W-1:0] zone_q;
    logic             late_q;
    logic [CNT_W-1:0] dl_load;
    logic [CNT_W-1:0] zn_load;

    // Compute load values from the declared length.
    always_comb begin
        dl_load = CNT_W'(dz_deadline(int'(len)));
        zn_load = CNT_W'(dz_zone_len(int'(len)));
    end

    // Zone status and first-miss pulse from registered state.
    always_comb begin
        miss    = pend && (ttd == '0) && !late_q;
        in_zone = pend && ((ttd < zone_q) || (ttd == '0));
    end

    // Track pending state, remaining time and the latched miss flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            ttd    <= '0;
            zone_q <= '0;
            late_q <= 1'b0;
        end else if (en) begin
            if (take) begin
                pend   <= 1'b0;
                late_q <= 1'b0;
            end else if (pend) begin
                if (ttd != '0) ttd <= ttd - 1'b1;
                if (miss) late_q <= 1'b1;
            end else if (req && !busy) begin
                pend   <= 1'b1;
                ttd    <= dl_load;
                zone_q <= zn_load;
                late_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dz_zone_pick.sv
// Module: selects the in-zone candidate with the least remaining time.
// Ties resolve to the lower index. Assumes non-candidates are masked off.
module dz_zone_pick #(
    parameter int N     = 4,
    parameter int CNT_W = 7,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            cand,
    input  logic [N-1:0][CNT_W-1:0] ttd,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);

    logic [CNT_W-1:0] best;

    // Linear scan keeping the strictly smaller remaining time.
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!hit || (ttd[i] < best))) begin
                hit  = 1'b1;
                best = ttd[i];
                idx  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dz_rr_pick.sv
// Module: rotating-priority picker; the first requester at or after the
// pointer wins, wrapping past the top index. Assumes ptr is below N.
module dz_rr_pick #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] ptr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    // Scan N positions starting at the pointer.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int off = 0; off < N; off++) begin
            int j;
            j = (int'(ptr) + off) % N;
            if (!hit && req[j]) begin
                hit = 1'b1;
                idx = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/dz_bus_arbiter.sv
// Module: deadline-aware warning-zone bus arbiter (top).
// Grants a shared bus non-preemptively. In-zone real-time requests win,
// otherwise a rotating pointer decides; idle grant goes to DFLT.
// Assumes requesters keep req high until granted and owners pulse done.
module dz_bus_arbiter #(
    parameter int             N       = 4,
    parameter int             LEN_W   = 6,
    parameter logic [N-1:0]   RT_MASK = 4'b0011,
    parameter int             DFLT    = 3,
    localparam int            IDX_W   = (N > 1) ? $clog2(N) : 1,
    localparam int            CNT_W   = LEN_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       req,
    input  logic [N*LEN_W-1:0] xfer_len,
    input  logic               done,
    output logic [N-1:0]       grant,
    output logic [IDX_W-1:0]   grant_id,
    output logic               held,
    output logic [N-1:0]       miss,
    output logic               cnt_clk_en
);

    logic [N-1:0][CNT_W-1:0] ttd_all;
    logic [N-1:0]            pend_all;
    logic [N-1:0]            zone_all;
    logic                    zone_hit;
    logic [IDX_W-1:0]        zone_idx;
    logic                    rr_hit;
    logic [IDX_W-1:0]        rr_idx;
    logic [IDX_W-1:0]        win;
    logic [IDX_W-1:0]        ptr_q;
    logic [IDX_W-1:0]        gid_q;
    logic                    held_q;
    logic                    take;

    // Per-master deadline tracking; non-real-time masters tie off.
    for (genvar g = 0; g < N; g++) begin : g_slot
        if (RT_MASK[g]) begin : g_rt
            dz_deadline_slot #(.LEN_W(LEN_W)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (cnt_clk_en),
                .req     (req[g]),
                .take    (take && (win == IDX_W'(g))),
                .busy    (held_q && (gid_q == IDX_W'(g))),
                .len     (xfer_len[g*LEN_W +: LEN_W]),
                .pend    (pend_all[g]),
                .ttd     (ttd_all[g]),
                .in_zone (zone_all[g]),
                .miss    (miss[g])
            );
        end else begin : g_nrt
            logic nrt_len_unused;
            assign nrt_len_unused = ^xfer_len[g*LEN_W +: LEN_W];
            assign pend_all[g] = 1'b0;
            assign ttd_all[g]  = '0;
            assign zone_all[g] = 1'b0;
            assign miss[g]     = 1'b0;
        end
    end

    dz_zone_pick #(.N(N), .CNT_W(CNT_W)) u_zone (
        .cand (zone_all & req),
        .ttd  (ttd_all),
        .hit  (zone_hit),
        .idx  (zone_idx)
    );

    dz_rr_pick #(.N(N)) u_rr (
        .req (req),
        .ptr (ptr_q),
        .hit (rr_hit),
        .idx (rr_idx)
    );

    // Winner: promoted request first, rotating choice otherwise.
    always_comb begin
        win  = zone_hit ? zone_idx : rr_idx;
        take = !held_q && rr_hit;
    end

    // Ownership, grant index and rotating pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            gid_q  <= IDX_W'(DFLT);
            ptr_q  <= '0;
        end else if (!held_q) begin
            if (take) begin
                held_q <= 1'b1;
                gid_q  <= win;
                ptr_q  <= (win == IDX_W'(N - 1)) ? '0 : win + 1'b1;
            end else begin
                gid_q  <= IDX_W'(DFLT);
            end
        end else if (done) begin
            held_q <= 1'b0;
            gid_q  <= IDX_W'(DFLT);
        end
    end

    // Output decode and counter clock enable.
    always_comb begin
        grant      = '0;
        grant[gid_q] = 1'b1;
        grant_id   = gid_q;
        held       = held_q;
        cnt_clk_en = (|(req & RT_MASK)) || (|pend_all);
    end

endmodule

// File: rtl/dz_bus_arbiter_chk.sv
// Module: property checker for the arbiter, bound to every instance.
// Assumes the same parameter values as the bound instance.
module dz_bus_arbiter_chk #(
    parameter int N    = 4,
    parameter int DFLT = 3,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     req,
    input logic             done,
    input logic [N-1:0]     grant,
    input logic [IDX_W-1:0] grant_id,
    input logic             held,
    input logic [N-1:0]     miss,
    input logic             cnt_clk_en
);

    assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(grant) && grant[grant_id]);

    assert_owner_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !done) |=> (held && $stable(grant_id)));

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (held && done) |=> (!held && grant_id == IDX_W'(DFLT)));

    assert_idle_default_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && req == '0) |=> (!held && grant_id == IDX_W'(DFLT)));

    assert_grant_to_requester_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && req != '0) |=> (held && (($past(req) & grant) != '0)));

    assert_miss_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (miss != '0) |=> ((miss & $past(miss)) == '0));

    assert_gate_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clk_en |-> (miss == '0));

endmodule

bind dz_bus_arbiter dz_bus_arbiter_chk #(.N(N), .DFLT(DFLT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .done       (done),
    .grant      (grant),
    .grant_id   (grant_id),
    .held       (held),
    .miss       (miss),
    .cnt_clk_en (cnt_clk_en)
);

// File: tb/sim_dz_bus_arbiter.sv
// Bench: behavioural reference model compared with the arbiter every cycle,
// plus directed scenarios with hand-derived expectations.
module sim_dz_bus_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 4;
    localparam int LEN_W = 6;
    localparam logic [N-1:0] RT = 4'b0011;
    localparam int DFLT  = 3;
    localparam int WDOG  = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     req = '0;
    logic [N*LEN_W-1:0] lens = '0;
    logic             done = 1'b0;
    logic [N-1:0]     grant;
    logic [1:0]       grant_id;
    logic             held;
    logic [N-1:0]     miss;
    logic             cnt_clk_en;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // reference model state
    int m_held, m_owner, m_ptr;
    int m_pend[N], m_ttd[N], m_wz[N], m_late[N];

    // handshake state
    bit seen = 0;
    int cnt = 0;
    int hold_len = 2;
    bit auto_gen = 0;
    bit force_done = 0;
    bit new_seen = 0;
    int new_gid = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dz_bus_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .xfer_len(lens), .done(done),
        .grant(grant), .grant_id(grant_id), .held(held), .miss(miss),
        .cnt_clk_en(cnt_clk_en)
    );

    function automatic int fdl(input int e);
        return e + e / 2 + e / 4;
    endfunction

    function automatic int fwz(input int e);
        return (e + fdl(e)) / 2;
    endfunction

    // Reference model: one step per rising edge.
    always @(posedge clk) begin
        int w, best, oh, oo, e;
        bit got;
        if (!rst_n) begin
            m_held = 0; m_owner = DFLT; m_ptr = 0;
            for (int i = 0; i < N; i++) begin
                m_pend[i] = 0; m_ttd[i] = 0; m_wz[i] = 0; m_late[i] = 0;
            end
        end else begin
            got = 0; w = 0; best = 0;
            for (int i = 0; i < N; i++)
                if (RT[i] && req[i] && m_pend[i] != 0 &&
                    (m_ttd[i] < m_wz[i] || m_ttd[i] == 0))
                    if (!got || m_ttd[i] < best) begin
                        got = 1; best = m_ttd[i]; w = i;
                    end
            for (int off = 0; off < N; off++)
                if (!got && req[(m_ptr + off) % N]) begin
                    got = 1; w = (m_ptr + off) % N;
                end
            oh = m_held; oo = m_owner;
            if (oh == 0) begin
                if (got) begin m_held = 1; m_owner = w; m_ptr = (w + 1) % N; end
                else m_owner = DFLT;
            end else if (done) begin
                m_held = 0; m_owner = DFLT;
            end
            for (int i = 0; i < N; i++) begin
                if (!RT[i]) continue;
                e = int'(lens[i*LEN_W +: LEN_W]);
                if (oh == 0 && got && w == i) begin
                    m_pend[i] = 0; m_late[i] = 0;
                end else if (m_pend[i] != 0) begin
                    if (m_ttd[i] == 0) m_late[i] = 1;
                    else m_ttd[i] = m_ttd[i] - 1;
                end else if (req[i] && !(oh != 0 && oo == i)) begin
                    m_pend[i] = 1; m_ttd[i] = fdl(e); m_wz[i] = fwz(e); m_late[i] = 0;
                end
            end
        end
    end

    task automatic check(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", rq, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int em, een;
        em = 0; een = 0;
        for (int i = 0; i < N; i++) begin
            if (m_pend[i] != 0 && m_ttd[i] == 0 && m_late[i] == 0) em |= (1 << i);
            if (m_pend[i] != 0 || (RT[i] && req[i])) een = 1;
        end
        check(tag, "grant_id", int'(grant_id), m_owner);
        check(tag, "held", int'(held), m_held);
        check("R3", "miss", int'(miss), em);
        check("R9", "cnt_clk_en", int'(cnt_clk_en), een);
        check("R10", "grant", int'(grant), 1 << int'(grant_id));
    endtask

    // Master-side behaviour: drop request on grant, finish after hold_len.
    task automatic handshake();
        if (held) begin
            if (!seen) begin
                seen = 1; req[grant_id] = 1'b0; cnt = hold_len;
                new_seen = 1; new_gid = int'(grant_id);
            end else if (cnt > 0) cnt--;
            done = (cnt == 0) || force_done;
        end else begin
            seen = 0;
            done = force_done;
        end
    endtask

    task automatic gen();
        hold_len = $urandom_range(0, 5);
        for (int i = 0; i < N; i++)
            if (!req[i] && !(held && grant_id == 2'(i)) && $urandom_range(0, 3) == 0) begin
                lens[i*LEN_W +: LEN_W] = LEN_W'($urandom_range(0, 63));
                req[i] = 1'b1;
            end
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
        handshake();
        if (auto_gen) gen();
    endtask

    task automatic wait_grant(output int g);
        int guard;
        guard = 0;
        new_seen = 0;
        while (!new_seen && guard < 300) begin tick(); guard++; end
        g = new_gid;
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        hold_len = 1;
        while ((req != '0 || held) && guard < 500) begin tick(); guard++; end
        tick();
    endtask

    task automatic set_len(input int i, input int e);
        lens[i*LEN_W +: LEN_W] = LEN_W'(e);
    endtask

    task automatic run_all();
        int g, k, miss_at;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "held in reset", int'(held), 0);
        check("R1", "grant_id in reset", int'(grant_id), DFLT);
        check("R1", "miss in reset", int'(miss), 0);
        check("R1", "cnt_clk_en in reset", int'(cnt_clk_en), 0);
        rst_n = 1'b1;
        tick();
        // R2: idle default grant
        tag = "R2";
        repeat (5) tick();
        check("R2", "idle grant_id", int'(grant_id), DFLT);
        // R6: rotating order among non-real-time and real-time requests
        tag = "R6";
        hold_len = 1;
        req = 4'b1110; set_len(1, 40);
        wait_grant(g); check("R6", "first rr winner", g, 1);
        wait_grant(g); check("R6", "second rr winner", g, 2);
        wait_grant(g); check("R6", "third rr winner", g, 3);
        drain();
        // R3: miss timing with E=4 -> D=7, miss seen on 8th cycle
        tag = "R3";
        hold_len = 30;
        req[3] = 1'b1;
        wait_grant(g);
        set_len(0, 4); req[0] = 1'b1;
        miss_at = 0;
        for (int j = 1; j <= 12; j++) begin
            tick();
            if (miss[0] && miss_at == 0) miss_at = j;
        end
        check("R3", "miss cycle for E=4", miss_at, 8);
        req[2] = 1'b1;
        hold_len = 1;
        wait_grant(g); check("R3", "late request first", g, 0);
        drain();
        // R4: in-zone RT beats the pointer's non-RT choice
        tag = "R4";
        hold_len = 10;
        set_len(1, 1); req[1] = 1'b1;
        wait_grant(g); check("R4", "owner before contest", g, 1);
        set_len(0, 2); req[0] = 1'b1; req[2] = 1'b1;
        hold_len = 1;
        wait_grant(g); check("R4", "zone over rotation", g, 0);
        drain();
        // R5: smallest remaining time, then tie to lower index
        tag = "R5";
        hold_len = 6;
        req[3] = 1'b1;
        wait_grant(g);
        set_len(0, 6); set_len(1, 3); req[1:0] = 2'b11;
        hold_len = 1;
        wait_grant(g); check("R5", "nearest deadline", g, 1);
        drain();
        hold_len = 20;
        req[3] = 1'b1;
        wait_grant(g);
        set_len(0, 5); set_len(1, 5); req[1:0] = 2'b11;
        hold_len = 1;
        wait_grant(g); check("R5", "tie to lower index", g, 0);
        drain();
        // R7: done while the bus is free has no effect
        tag = "R7";
        force_done = 1;
        repeat (4) tick();
        check("R7", "held after stray done", int'(held), 0);
        force_done = 0;
        tick();
        // R8: long random traffic
        tag = "R8";
        auto_gen = 1;
        for (k = 0; k < 4000; k++) tick();
        auto_gen = 0;
        drain();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WDOG) @(posedge clk);
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule